// File: doc/BRIEF.md
# Satellite Control Tone and Message Transmitter

This block drives the control line of a satellite receiver installation. A phase accumulator produces a 22 kHz square carrier. The block gates that carrier in three ways. It can send a steady tone. It can send a short tone burst that selects position A or B. It can send a command of one to six bytes, where each bit is pulse-width modulated. A host works through a byte-wide register port. It loads the command bytes into a buffer, writes a single control word that starts the transfer, and then polls a ready bit until the line has finished and settled.

Time is counted in units of half a millisecond. The parameter `UNIT_CYC` sets how many clock cycles make one unit. A data bit lasts three units. A '0' is two units of tone and then one unit of silence. A '1' is one unit of tone and then two units of silence. Each byte goes out with its most significant bit first, followed by an odd parity bit. Burst A is 25 units of unbroken tone. Burst B is nine '1' bits. Every transfer ends with 30 units of silence, and the ready bit rises only after that.

The sequencer is a state machine with these states:
- `S_IDLE`
- `S_MSG`
- `S_BURST_A`
- `S_BURST_B`
- `S_GUARD`

Its transitions are:
- *start-message*: IDLE to MSG.
- *start-burst-a*: IDLE to BURST_A.
- *start-burst-b*: IDLE to BURST_B.
- *message-done*: MSG to GUARD, after the parity bit of the last byte.
- *burst-a-done*: BURST_A to GUARD, after 25 units.
- *burst-b-done*: BURST_B to GUARD, after nine bits.
- *guard-done*: GUARD to IDLE, after 30 units.

Top module: `sec_line_tx`

Register map (4-bit address):

| Address | Contents |
|---|---|
| 0x0 | Control register |
| 0x1 | Status register; bit 0 is the ready flag |
| 0x2 | Phase increment, low byte |
| 0x3 | Phase increment, high byte |
| 0x8 to 0xD | Message buffer, with byte 0 at 0x8 |

Control register fields:

| Bits | Meaning |
|---|---|
| bit 0 | Steady tone enable |
| bit 1 | Selects burst B instead of burst A |
| bit 2 | Starts a burst |
| bit 3 | Starts a message |
| bits 6:4 | Message length minus one |
| bit 7 | Turns off the internal carrier |

## Requirements
- R1: After a synchronous reset the ready bit reads 1. The control register, the status bits other than bit 0 and all six buffer bytes read 0. `tone_env` and `line_tone` are 0.
- R2: Buffer bytes written at 0x8 to 0xD read back unchanged. The phase increment reads back low byte at 0x2 and high byte at 0x3. Unmapped addresses read 0.
- R3: While idle with control bit 0 set, `tone_env` is 1. The carrier is bit 18 of a 19-bit accumulator that adds the phase increment every cycle, so over 2^19/inc cycles it is high for exactly half of them.
- R4: Control bit 7 holds `line_tone` at 0 while `tone_env` keeps its value.
- R5: Writing a control value with bit 3 set sends buffer bytes 0 to N-1, where N is bits 6:4 plus one. Bits go MSB first with the unit pattern given above, and an odd parity bit follows each byte.
- R6: A control value with bit 3 clear and bit 2 set sends burst A (25 units of tone) when bit 1 is 0, and burst B (nine '1' bits) when bit 1 is 1.
- R7: From the cycle after the start write until the end of a 30-unit silent guard, the ready bit reads 0 and `tone_env` follows only the transfer pattern. Steady tone is suppressed in this window.
- R8: While ready is 0, writes to the control register and to the buffer are ignored. The transfer in progress continues unchanged, and the ignored registers keep their values.
- R9: A control write while idle with bits 3 and 2 clear takes effect on the next cycle and starts no transfer.
- R10: A length field of 6 or 7 sends six bytes.
- R11: When bits 3 and 2 are both set, a message is sent, not a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tone_env | output | 1 | Tone envelope: 1 while the line should carry tone |
| line_tone | output | 1 | Gated 22 kHz carrier |

## Verification
The assertions take for granted that every start pulse reaching the sequencer arrives while it is idle. They also take for granted that the length handed over is already clamped to the buffer size. Both hold because the register file qualifies start writes with the ready flag and clamps the length field. The stimulus deliberately writes the control register and the buffer during a burst to check that the register file enforces this. The stimulus gives `wr_en` and `addr` new values only half a cycle away from the active edge and holds each write for one cycle. It also never applies reset during a transfer except at the start.

// File: rtl/sec_pkg.sv
package sec_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MSG,
        S_BURST_A,
        S_BURST_B,
        S_GUARD
    } seq_state_t;

    localparam int CTL_TONE    = 0;
    localparam int CTL_BSEL    = 1;
    localparam int CTL_BURST   = 2;
    localparam int CTL_MSG     = 3;
    localparam int CTL_LEN_LSB = 4;
    localparam int CTL_EXT     = 7;

endpackage

// File: rtl/sec_nco.sv
module sec_nco #(
    parameter int INC_W = 16,
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc_i,
    output logic             carrier_o
);
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_q + ACC_W'(inc_i);
    end

    assign carrier_o = acc_q[ACC_W-1];

    // R3
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc_q == ACC_W'($past(acc_q) + ACC_W'($past(inc_i))));
endmodule

// File: rtl/sec_regs.sv
module sec_regs
    import sec_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          MAX_BYTES = 6,
    parameter int          MSG_BASE  = 8,
    parameter int          INC_W     = 16,
    parameter logic [15:0] INC_RST   = 16'd120,
    localparam int         LEN_W     = $clog2(MAX_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic                   ready_i,
    output logic                   start_o,
    output logic                   cmd_o,
    output logic                   bsel_o,
    output logic [LEN_W-1:0]       len_m1_o,
    output logic [7:0]             ctrl_o,
    output logic [INC_W-1:0]       inc_o,
    output logic [MAX_BYTES*8-1:0] buf_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_INCL = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_INCH = ADDR_W'(3);

    logic [7:0]       ctrl_q;
    logic [INC_W-1:0] inc_q;
    logic             ctrl_wr;

    assign ctrl_wr = we && (addr == A_CTRL) && ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            inc_q  <= INC_W'(INC_RST);
        end else begin
            if (ctrl_wr) ctrl_q <= wdata;
            if (we && addr == A_INCL) inc_q[7:0]       <= wdata;
            if (we && addr == A_INCH) inc_q[INC_W-1:8] <= wdata[INC_W-9:0];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < MAX_BYTES; gi++) begin : g_buf
            localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(MSG_BASE + gi);
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)                              byte_q <= '0;
                else if (we && addr == A_BYTE && ready_i) byte_q <= wdata;
            end
            assign buf_o[gi*8 +: 8] = byte_q;

            // R8
            busy_buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (we && addr == A_BYTE && !ready_i) |=> $stable(byte_q));
        end
    endgenerate

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_STAT:  rdata = {7'b0, ready_i};
            A_INCL:  rdata = inc_q[7:0];
            A_INCH:  rdata = 8'(inc_q[INC_W-1:8]);
            default: begin
                for (int i = 0; i < MAX_BYTES; i++)
                    if (addr == ADDR_W'(MSG_BASE + i)) rdata = buf_o[i*8 +: 8];
            end
        endcase
    end

    logic [2:0] len_field;
    assign len_field = wdata[CTL_LEN_LSB +: 3];
    assign start_o   = ctrl_wr && (wdata[CTL_MSG] || wdata[CTL_BURST]);
    assign cmd_o     = wdata[CTL_MSG];
    assign bsel_o    = wdata[CTL_BSEL];
    assign len_m1_o  = (int'(len_field) > MAX_BYTES - 1) ? LEN_W'(MAX_BYTES - 1)
                                                         : LEN_W'(len_field);
    assign ctrl_o    = ctrl_q;
    assign inc_o     = inc_q;

    // R8
    busy_ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CTRL && !ready_i) |=> $stable(ctrl_q));
    // R1
    reset_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ctrl_q == 8'h00);
endmodule

// File: rtl/sec_seq.sv
module sec_seq
    import sec_pkg::*;
#(
    parameter int  MAX_BYTES     = 6,
    parameter int  UNIT_CYC      = 48000,
    parameter int  BURST_A_UNITS = 25,
    parameter int  BURST_B_BITS  = 9,
    parameter int  GUARD_UNITS   = 30,
    localparam int LEN_W         = $clog2(MAX_BYTES),
    localparam int DIV_W         = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1,
    localparam int CNT_W         = $clog2(((BURST_A_UNITS > GUARD_UNITS) ? BURST_A_UNITS : GUARD_UNITS) + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   cmd_i,
    input  logic                   bsel_i,
    input  logic [LEN_W-1:0]       len_m1_i,
    input  logic [MAX_BYTES*8-1:0] buf_i,
    output logic                   ready_o,
    output logic                   mark_o
);
    seq_state_t       state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       slot_q;
    logic [3:0]       bit_q;
    logic [LEN_W-1:0] byte_q;
    logic [LEN_W-1:0] last_q;
    logic             tick;
    logic [7:0]       cur_byte;
    logic             cur_bit;
    logic             bit_end;

    assign tick     = (div_q == DIV_W'(UNIT_CYC - 1));
    assign cur_byte = buf_i[int'(byte_q)*8 +: 8];
    assign cur_bit  = (state_q == S_BURST_B) ? 1'b1 :
                      (bit_q == 4'd8) ? ~^cur_byte : cur_byte[3'd7 - bit_q[2:0]];
    assign bit_end  = tick && (slot_q == 2'd2);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = cmd_i ? S_MSG : (bsel_i ? S_BURST_B : S_BURST_A);
            S_MSG:     if (bit_end && bit_q == 4'd8 && byte_q == last_q) state_d = S_GUARD;
            S_BURST_A: if (tick && cnt_q == CNT_W'(BURST_A_UNITS - 1)) state_d = S_GUARD;
            S_BURST_B: if (bit_end && bit_q == 4'(BURST_B_BITS - 1)) state_d = S_GUARD;
            S_GUARD:   if (tick && cnt_q == CNT_W'(GUARD_UNITS - 1)) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            div_q   <= '0;
            cnt_q   <= '0;
            slot_q  <= '0;
            bit_q   <= '0;
            byte_q  <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE) begin
                div_q  <= '0;
                cnt_q  <= '0;
                slot_q <= '0;
                bit_q  <= '0;
                byte_q <= '0;
                if (start_i) last_q <= len_m1_i;
            end else if (tick) begin
                div_q <= '0;
                if (state_d != state_q) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
                if (slot_q == 2'd2) begin
                    slot_q <= '0;
                    if (bit_q == 4'd8 || (state_q == S_BURST_B && bit_q == 4'(BURST_B_BITS - 1))) begin
                        bit_q  <= '0;
                        byte_q <= byte_q + 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        mark_o  = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            S_IDLE:              ready_o = 1'b1;
            S_MSG, S_BURST_B:    mark_o  = (slot_q == 2'd0) || (slot_q == 2'd1 && !cur_bit);
            S_BURST_A:           mark_o  = 1'b1;
            S_GUARD:             mark_o  = 1'b0;
            default:             mark_o  = 1'b0;
        endcase
    end

    // R7
    ready_after_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(state_q == S_GUARD && !mark_o));
    // R8
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |-> ready_o);
    // R7
    start_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !ready_o);
    // R6
    burst_a_len_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == S_BURST_A |-> cnt_q < CNT_W'(BURST_A_UNITS));
    // R10
    byte_bound_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == S_MSG |-> (byte_q <= last_q && int'(last_q) < MAX_BYTES));
endmodule

// File: rtl/sec_line_tx.sv
module sec_line_tx
    import sec_pkg::*;
#(
    parameter int          UNIT_CYC  = 48000,
    parameter int          MAX_BYTES = 6,
    parameter logic [15:0] INC_RST   = 16'd120
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       tone_env,
    output logic       line_tone
);
    localparam int LEN_W = $clog2(MAX_BYTES);

    logic                   ready, start, cmd, bsel, mark, carrier;
    logic [LEN_W-1:0]       len_m1;
    logic [7:0]             ctrl;
    logic [15:0]            inc;
    logic [MAX_BYTES*8-1:0] msg_buf;

    sec_regs #(
        .ADDR_W(4), .MAX_BYTES(MAX_BYTES), .MSG_BASE(8), .INC_W(16), .INC_RST(INC_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .we(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ready_i(ready), .start_o(start), .cmd_o(cmd), .bsel_o(bsel), .len_m1_o(len_m1),
        .ctrl_o(ctrl), .inc_o(inc), .buf_o(msg_buf)
    );

    sec_seq #(
        .MAX_BYTES(MAX_BYTES), .UNIT_CYC(UNIT_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .start_i(start), .cmd_i(cmd), .bsel_i(bsel),
        .len_m1_i(len_m1), .buf_i(msg_buf), .ready_o(ready), .mark_o(mark)
    );

    sec_nco #(.INC_W(16), .ACC_W(19)) u_nco (
        .clk(clk), .rst(rst), .inc_i(inc), .carrier_o(carrier)
    );

    assign tone_env  = ready ? ctrl[CTL_TONE] : mark;
    assign line_tone = carrier && tone_env && !ctrl[CTL_EXT];

    // R4
    ext_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl[CTL_EXT] |-> !line_tone);
    // R7
    busy_no_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !mark) |-> !tone_env);
endmodule

// File: tb/sec_line_tx_test.sv
module sec_line_tx_test;
    localparam int UNIT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tone_env, line_tone;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    bit exp_u [0:511];
    int n_units;
    logic [7:0] msg [0:5];

    always #4 clk = ~clk;

    sec_line_tx #(.UNIT_CYC(UNIT)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tone_env(tone_env), .line_tone(line_tone)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // write at a negedge, returns at the negedge after the capturing edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'h1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
        addr = 4'h1;
    endtask

    task automatic add_bit(input bit b);
        exp_u[n_units]   = 1'b1;
        exp_u[n_units+1] = !b;
        exp_u[n_units+2] = 1'b0;
        n_units += 3;
    endtask

    task automatic add_guard();
        for (int i = 0; i < 30; i++) exp_u[n_units + i] = 1'b0;
        n_units += 30;
    endtask

    task automatic build_msg(input int nbytes);
        n_units = 0;
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) add_bit(msg[b][i]);
            add_bit(~^msg[b]);
        end
        add_guard();
    endtask

    // run one transfer started by ctrl value cv, optionally injecting writes while busy
    task automatic run(input string req, input logic [7:0] cv, input bit inject);
        int bad_env = 0, bad_rdy = 0, first = -1;
        logic [7:0] st;
        wr(4'h0, cv);
        for (int k = 0; k < n_units * UNIT; k++) begin
            if (tone_env !== exp_u[k / UNIT]) begin
                bad_env++;
                if (first < 0) first = k;
            end
            if (inject && (k == 20 || k == 22)) begin
                addr = (k == 20) ? 4'h0 : 4'h8;
                wdata = (k == 20) ? 8'h08 : 8'hA5;
                wr_en = 1'b1;
            end else begin
                wr_en = 1'b0;
                rd(4'h1, st);
                if (st[0] !== 1'b0) bad_rdy++;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        addr = 4'h1;
        check(req, $sformatf("envelope mismatches (first at cycle %0d)", first), bad_env, 0);
        check("R7", "ready low during transfer mismatches", bad_rdy, 0);
        rd(4'h1, st);
        check("R7", "ready after guard", int'(st[0]), 1);
        check("R7", "envelope after guard follows ctrl bit0", int'(tone_env), int'(cv[0]));
    endtask

    initial begin
        logic [7:0] v;
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h1, v); check("R1", "status after reset", v, 8'h01);
        rd(4'h0, v); check("R1", "ctrl after reset", v, 8'h00);
        for (int i = 0; i < 6; i++) begin
            rd(4'(8 + i), v); check("R1", "buffer after reset", v, 0);
        end
        check("R1", "tone_env after reset", tone_env, 0);
        check("R1", "line_tone after reset", line_tone, 0);

        // R2 readback
        for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'(8'h3C ^ (i * 37)));
        for (int i = 0; i < 6; i++) begin
            rd(4'(8 + i), v); check("R2", "buffer readback", v, 8'(8'h3C ^ (i * 37)));
        end
        wr(4'h2, 8'h00); wr(4'h3, 8'h40);
        rd(4'h2, v); check("R2", "inc low", v, 8'h00);
        rd(4'h3, v); check("R2", "inc high", v, 8'h40);
        rd(4'h5, v); check("R2", "unmapped read", v, 8'h00);
        rd(4'hF, v); check("R2", "unmapped read", v, 8'h00);

        // R9 + R3: steady tone, inc 0x4000 -> period 32 cycles
        wr(4'h0, 8'h01);
        check("R9", "steady tone next cycle", tone_env, 1);
        rd(4'h1, v); check("R9", "no transfer started", v, 8'h01);
        hi = 0;
        for (int k = 0; k < 320; k++) begin
            hi += int'(line_tone);
            @(negedge clk);
        end
        check("R3", "carrier high cycles in 10 periods", hi, 160);

        // R4 external tone source
        wr(4'h0, 8'h81);
        hi = 0;
        for (int k = 0; k < 320; k++) begin
            hi += int'(line_tone);
            if (tone_env !== 1'b1) hi += 1000;
            @(negedge clk);
        end
        check("R4", "line_tone with bit7 (env held 1)", hi, 0);
        wr(4'h0, 8'h00);
        check("R9", "tone off next cycle", tone_env, 0);

        // R5 sweep of lengths 1..6
        msg[0] = 8'hE2; msg[1] = 8'h10; msg[2] = 8'h38;
        msg[3] = 8'h00; msg[4] = 8'hFF; msg[5] = 8'h5A;
        for (int i = 0; i < 6; i++) wr(4'(8 + i), msg[i]);
        for (int n = 1; n <= 6; n++) begin
            build_msg(n);
            run("R5", 8'(8'h08 | ((n - 1) << 4)), 1'b0);
        end

        // R5 sweep of single-byte values, parity corner cases
        for (int j = 0; j < 16; j++) begin
            msg[0] = 8'(j * 17 + (j & 1));
            wr(4'h8, msg[0]);
            build_msg(1);
            run("R5", 8'h08, 1'b0);
        end

        // R7 steady tone enabled in the start word resumes only after guard
        build_msg(1);
        run("R7", 8'h09, 1'b0);
        wr(4'h0, 8'h00);

        // R10 length field 6 and 7 clamp to six bytes
        msg[0] = 8'hE2; msg[1] = 8'h10; msg[2] = 8'h38;
        msg[3] = 8'h00; msg[4] = 8'hFF; msg[5] = 8'h5A;
        for (int i = 0; i < 6; i++) wr(4'(8 + i), msg[i]);
        build_msg(6);
        run("R10", 8'h68, 1'b0);
        run("R10", 8'h78, 1'b0);

        // R11 both start bits: message wins
        build_msg(1);
        run("R11", 8'h0C, 1'b0);

        // R6 burst A
        n_units = 0;
        for (int i = 0; i < 25; i++) exp_u[i] = 1'b1;
        n_units = 25;
        add_guard();
        run("R6", 8'h04, 1'b0);

        // R8 burst A with ignored writes while busy
        run("R8", 8'h04, 1'b1);
        rd(4'h0, v); check("R8", "ctrl kept during busy write", v, 8'h04);
        rd(4'h8, v); check("R8", "buffer kept during busy write", v, 8'hE2);

        // R6 burst B
        n_units = 0;
        for (int i = 0; i < 9; i++) add_bit(1'b1);
        add_guard();
        run("R6", 8'h06, 1'b0);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule